// File: doc/BRIEF.md
# Banked Data Memory Access Arbiter

This block sits between the load/store units of a core and a data store made of several single-ported word-wide RAM banks. It takes two load requests and one retiring store from the store buffer each cycle, works out which bank each one targets from the low bits of its word address, and grants every request whose bank is free. Two requests that land in different banks both proceed in the same cycle. Two requests that land in the same bank are serialized: the loser sees a hold indication, keeps its request asserted, and is granted in a later cycle.

Loads always win a bank over the store. Load port 0 always wins over load port 1, so port 0 never waits. Port 1 waits only on a bank collision with port 0. The store waits whenever either load uses its bank. Each granted load reads its bank, and the word appears one cycle later on a return lane that belongs to the requesting port. A granted store writes its bank at the same clock edge. The banks are plain RAMs inside the block. There are no tags and no miss handling.

Top module: `dcache_bank_arbiter`

## Requirements
- R1: When both loads are requested and their bank indices differ, `ld1_stall` is low and both loads are granted in that cycle.
- R2: A word address selects bank `waddr[BANK_W-1:0]` and row `waddr[WADDR_W-1:BANK_W]`. Each of the NUM_BANKS banks, and each row within a bank, holds its own word.
- R3: When both loads target the same bank, port 0 is granted and `ld1_stall` is high. A port-1 request that is still held is granted in the first cycle in which port 0 does not claim that bank.
- R4: `st_grant` is low in any cycle in which a requested load (on either port) targets the store's bank.
- R5: `st_grant` is high whenever `st_req` is high and no load targets the store's bank, including cycles in which loads to other banks are granted.
- R6: A granted load raises its own port's `rdN_valid` exactly one cycle after the grant. A stalled or absent request raises no valid on that lane.
- R7: A load and a store to the same word in the same cycle return the word as it was before the store, and the store is not granted that cycle.
- R8: While `rst_n` is low, and in the first cycle after it, both return valids are low.
- R9: A granted store's data is returned by any later load of that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld0_req | input | 1 | Load port 0 request (always granted) |
| ld0_waddr | input | WADDR_W | Load port 0 word address |
| ld1_req | input | 1 | Load port 1 request, held by the requester while stalled |
| ld1_waddr | input | WADDR_W | Load port 1 word address |
| ld1_stall | output | 1 | Port 1 lost a bank collision this cycle |
| st_req | input | 1 | Store-buffer retirement request, held until granted |
| st_waddr | input | WADDR_W | Store word address |
| st_wdata | input | DATA_W | Store data |
| st_grant | output | 1 | Store written at this clock edge |
| rd0_valid | output | 1 | Port 0 load data valid |
| rd0_data | output | DATA_W | Port 0 load data |
| rd1_valid | output | 1 | Port 1 load data valid |
| rd1_data | output | DATA_W | Port 1 load data |

## Verification
The bench builds the block with its defaults: eight banks, sixteen rows per bank and a 32-bit word, which gives a 7-bit word address. With these values, words 0 to 15 cover every bank in two rows. Addresses that differ by eight therefore collide on a bank while sitting in different rows. This makes it possible to check load/load collisions, store/load collisions on either port, and same-word races, with known data in every bank.

// File: rtl/dcb_pkg.sv
// Shared types for the banked data memory arbiter.
// Assumes: two load ports and one store port feed the arbiter.
package dcb_pkg;

    localparam int LD_PORTS = 2;

    // Which requester owns a bank in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LD0  = 2'd1,
        SRC_LD1  = 2'd2,
        SRC_ST   = 2'd3
    } bank_src_e;

endpackage

// File: rtl/dcb_bank_ram.sv
// One single-ported word-wide data bank with a registered read.
// Assumes: the arbiter never asserts read and write in the same cycle.
module dcb_bank_ram #(
    parameter int DATA_W = 32,
    parameter int ROWS   = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ROWS];

    // Storage access: write when granted to the store, capture read word for loads.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_row];
        end
    end

endmodule

// File: rtl/dcb_arbiter.sv
// Bank conflict arbiter: load 0 beats load 1, both loads beat the store.
// Assumes: requesters hold their request until it is granted.
module dcb_arbiter
    import dcb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                         ld0_req,
    input  logic [BANK_W-1:0]            ld0_bank,
    input  logic                         ld1_req,
    input  logic [BANK_W-1:0]            ld1_bank,
    input  logic                         st_req,
    input  logic [BANK_W-1:0]            st_bank,
    output logic                         ld1_go,
    output logic                         st_go,
    output bank_src_e [NUM_BANKS-1:0]    bank_src
);

    // Requester-level grants: port 1 yields to port 0, store yields to any granted load.
    always_comb begin
        ld1_go = ld1_req && !(ld0_req && (ld0_bank == ld1_bank));
        st_go  = st_req
              && !(ld0_req && (ld0_bank == st_bank))
              && !(ld1_go  && (ld1_bank == st_bank));
    end

    // Per-bank owner selection, in priority order.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            if (ld0_req && (ld0_bank == BANK_W'(b))) begin
                bank_src[b] = SRC_LD0;
            end else if (ld1_go && (ld1_bank == BANK_W'(b))) begin
                bank_src[b] = SRC_LD1;
            end else if (st_go && (st_bank == BANK_W'(b))) begin
                bank_src[b] = SRC_ST;
            end else begin
                bank_src[b] = SRC_NONE;
            end
        end
    end

endmodule

// File: rtl/dcb_resp_lane.sv
// Return lane for one load port: remembers the granted bank for one cycle
// and selects that bank's registered read word.
// Assumes: bank read words are registered at the same edge as the grant.
module dcb_resp_lane #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               go,
    input  logic [BANK_W-1:0]                  bank,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata,
    output logic                               valid,
    output logic [DATA_W-1:0]                  data
);

    logic [BANK_W-1:0] bank_q;

    // Grant tracking: valid and bank of the access returning next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            bank_q <= '0;
        end else begin
            valid  <= go;
            bank_q <= bank;
        end
    end

    // Data select from the bank that served this port.
    always_comb begin
        data = bank_rdata[bank_q];
    end

endmodule

// File: rtl/dcache_bank_arbiter.sv
// Top: two load ports and one store port onto NUM_BANKS interleaved banks.
// Assumes: word addresses; bank index in the low bits, row above it.
module dcache_bank_arbiter
    import dcb_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROWS      = 16,
    parameter int DATA_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = $clog2(ROWS),
    localparam int WADDR_W  = BANK_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld0_req,
    input  logic [WADDR_W-1:0] ld0_waddr,
    input  logic               ld1_req,
    input  logic [WADDR_W-1:0] ld1_waddr,
    output logic               ld1_stall,
    input  logic               st_req,
    input  logic [WADDR_W-1:0] st_waddr,
    input  logic [DATA_W-1:0]  st_wdata,
    output logic               st_grant,
    output logic               rd0_valid,
    output logic [DATA_W-1:0]  rd0_data,
    output logic               rd1_valid,
    output logic [DATA_W-1:0]  rd1_data
);

    logic                             ld1_go;
    logic                             st_go;
    bank_src_e [NUM_BANKS-1:0]        bank_src;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [LD_PORTS-1:0]              ld_go;
    logic [LD_PORTS-1:0][BANK_W-1:0]  ld_bank;
    logic [LD_PORTS-1:0]              lane_valid;
    logic [LD_PORTS-1:0][DATA_W-1:0]  lane_data;

    // Address split and port-level outputs.
    always_comb begin
        ld_bank[0] = ld0_waddr[BANK_W-1:0];
        ld_bank[1] = ld1_waddr[BANK_W-1:0];
        ld_go[0]   = ld0_req;
        ld_go[1]   = ld1_go;
        ld1_stall  = ld1_req && !ld1_go;
        st_grant   = st_go;
    end

    dcb_arbiter #(
        .NUM_BANKS (NUM_BANKS)
    ) u_arb (
        .ld0_req  (ld0_req),
        .ld0_bank (ld_bank[0]),
        .ld1_req  (ld1_req),
        .ld1_bank (ld_bank[1]),
        .st_req   (st_req),
        .st_bank  (st_waddr[BANK_W-1:0]),
        .ld1_go   (ld1_go),
        .st_go    (st_go),
        .bank_src (bank_src)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             rd_en;
        logic             wr_en;
        logic [ROW_W-1:0] rd_row;

        // Bank port steering from the arbiter's owner choice.
        always_comb begin
            rd_en  = (bank_src[b] == SRC_LD0) || (bank_src[b] == SRC_LD1);
            wr_en  = (bank_src[b] == SRC_ST);
            rd_row = (bank_src[b] == SRC_LD1) ? ld1_waddr[WADDR_W-1:BANK_W]
                                              : ld0_waddr[WADDR_W-1:BANK_W];
        end

        dcb_bank_ram #(
            .DATA_W (DATA_W),
            .ROWS   (ROWS)
        ) u_ram (
            .clk     (clk),
            .rd_en   (rd_en),
            .rd_row  (rd_row),
            .wr_en   (wr_en),
            .wr_row  (st_waddr[WADDR_W-1:BANK_W]),
            .wr_data (st_wdata),
            .rd_data (bank_rdata[b])
        );
    end

    for (genvar p = 0; p < LD_PORTS; p++) begin : g_lane
        dcb_resp_lane #(
            .NUM_BANKS (NUM_BANKS),
            .DATA_W    (DATA_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .go         (ld_go[p]),
            .bank       (ld_bank[p]),
            .bank_rdata (bank_rdata),
            .valid      (lane_valid[p]),
            .data       (lane_data[p])
        );
    end

    // Return lanes to ports.
    always_comb begin
        rd0_valid = lane_valid[0];
        rd0_data  = lane_data[0];
        rd1_valid = lane_valid[1];
        rd1_data  = lane_data[1];
    end

endmodule

// File: rtl/dcache_bank_arbiter_chk.sv
// Protocol checker for dcache_bank_arbiter, bound to every instance.
// Assumes: same parameters as the bound top.
module dcache_bank_arbiter_chk #(
    parameter int NUM_BANKS = 8,
    parameter int ROWS      = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int WADDR_W  = BANK_W + $clog2(ROWS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld0_req,
    input logic [WADDR_W-1:0] ld0_waddr,
    input logic               ld1_req,
    input logic [WADDR_W-1:0] ld1_waddr,
    input logic               ld1_stall,
    input logic               st_req,
    input logic [WADDR_W-1:0] st_waddr,
    input logic               st_grant,
    input logic               rd0_valid,
    input logic               rd1_valid
);

    logic same01, same0s, same1s;
    always_comb begin
        same01 = ld0_waddr[BANK_W-1:0] == ld1_waddr[BANK_W-1:0];
        same0s = ld0_waddr[BANK_W-1:0] == st_waddr[BANK_W-1:0];
        same1s = ld1_waddr[BANK_W-1:0] == st_waddr[BANK_W-1:0];
    end

    p_distinct_banks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld0_req && ld1_req && !same01) |-> !ld1_stall);

    p_conflict_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld0_req && ld1_req && same01) |-> ld1_stall);

    p_store_yields_ld0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && ld0_req && same0s) |-> !st_grant);

    p_store_yields_ld1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && ld1_req && same1s) |-> !st_grant);

    p_store_free_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !(ld0_req && same0s) && !(ld1_req && same1s)) |-> st_grant);

    p_port0_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld0_req |=> rd0_valid);

    p_port1_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld1_req && !ld1_stall) |=> rd1_valid);

    p_port1_no_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld1_req && !ld1_stall) |=> !rd1_valid);

    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (!rd0_valid && !rd1_valid));

endmodule

bind dcache_bank_arbiter dcache_bank_arbiter_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ROWS      (ROWS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld0_req   (ld0_req),
    .ld0_waddr (ld0_waddr),
    .ld1_req   (ld1_req),
    .ld1_waddr (ld1_waddr),
    .ld1_stall (ld1_stall),
    .st_req    (st_req),
    .st_waddr  (st_waddr),
    .st_grant  (st_grant),
    .rd0_valid (rd0_valid),
    .rd1_valid (rd1_valid)
);

// File: tb/dcache_bank_arbiter_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts grants and return words from the
// requirements and queues them; the monitor compares the return lanes.
module dcache_bank_arbiter_test;

    localparam int NB  = 8;
    localparam int NR  = 16;
    localparam int DW  = 32;
    localparam int AW  = 7;
    localparam int BW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld0_req = 1'b0, ld1_req = 1'b0, st_req = 1'b0;
    logic [AW-1:0] ld0_waddr = '0, ld1_waddr = '0, st_waddr = '0;
    logic [DW-1:0] st_wdata = '0;
    logic          ld1_stall, st_grant, rd0_valid, rd1_valid;
    logic [DW-1:0] rd0_data, rd1_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] mdl [NB*NR];
    logic [DW:0]   q0 [$];
    logic [DW:0]   q1 [$];
    string         t0 [$];
    string         t1 [$];

    always #10 clk = ~clk;

    dcache_bank_arbiter #(.NUM_BANKS(NB), .ROWS(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ld0_req(ld0_req), .ld0_waddr(ld0_waddr),
        .ld1_req(ld1_req), .ld1_waddr(ld1_waddr), .ld1_stall(ld1_stall),
        .st_req(st_req), .st_waddr(st_waddr), .st_wdata(st_wdata), .st_grant(st_grant),
        .rd0_valid(rd0_valid), .rd0_data(rd0_data),
        .rd1_valid(rd1_valid), .rd1_data(rd1_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of requests, with predicted grants and return words.
    task automatic cyc(input bit l0, input int a0, input bit l1, input int a1,
                       input bit s, input int sa, input logic [DW-1:0] sd, input string tag);
        bit stall, sgo;
        @(negedge clk);
        ld0_req = l0; ld0_waddr = AW'(a0);
        ld1_req = l1; ld1_waddr = AW'(a1);
        st_req = s;   st_waddr = AW'(sa); st_wdata = sd;
        stall = l0 && l1 && (a0 % NB == a1 % NB);
        sgo   = s && !(l0 && (a0 % NB == sa % NB)) && !(l1 && (a1 % NB == sa % NB));
        #5;
        chk({tag, " ld1_stall"}, DW'(ld1_stall), DW'(stall));
        chk({tag, " st_grant"}, DW'(st_grant), DW'(sgo));
        q0.push_back({l0, l0 ? mdl[a0] : '0});
        t0.push_back(tag);
        q1.push_back({l1 && !stall, (l1 && !stall) ? mdl[a1] : '0});
        t1.push_back(tag);
        if (sgo) mdl[sa] = sd;
    endtask

    // Monitor: compare each lane shortly after the edge that returns data.
    always @(posedge clk) begin
        logic [DW:0] e;
        string tg;
        #2;
        if (q0.size() > 0) begin
            e = q0.pop_front(); tg = t0.pop_front();
            chk({tg, " R6 rd0_valid"}, DW'(rd0_valid), DW'(e[DW]));
            if (e[DW]) chk({tg, " rd0_data"}, rd0_data, e[DW-1:0]);
        end
        if (q1.size() > 0) begin
            e = q1.pop_front(); tg = t1.pop_front();
            chk({tg, " R6 rd1_valid"}, DW'(rd1_valid), DW'(e[DW]));
            if (e[DW]) chk({tg, " rd1_data"}, rd1_data, e[DW-1:0]);
        end
    end

    initial begin
        for (int i = 0; i < NB*NR; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk("R8 rd0_valid in reset", DW'(rd0_valid), 0);
        chk("R8 rd1_valid in reset", DW'(rd1_valid), 0);
        chk("R8 st_grant idle", DW'(st_grant), 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R8 rd0_valid after reset", DW'(rd0_valid), 0);
        chk("R8 rd1_valid after reset", DW'(rd1_valid), 0);

        // Fill every bank in two rows with stores alone.
        for (int w = 0; w < 16; w++) cyc(0, 0, 0, 0, 1, w, 32'hA000_0000 + w, "R5 fill");
        // Distinct-bank load pairs.
        cyc(1, 0, 1, 1, 0, 0, 0, "R1 b0/b1");
        cyc(1, 10, 1, 7, 0, 0, 0, "R1 b2/b7");
        cyc(1, 15, 1, 8, 0, 0, 0, "R1 R2 b7/b0 row1");
        cyc(1, 0, 1, 8, 0, 0, 0, "R2 R3 same bank rows 0/1");
        cyc(0, 0, 1, 8, 0, 0, 0, "R3 held port1");
        // Port collision while the store uses a third bank.
        cyc(1, 3, 1, 11, 1, 5, 32'h5555_0005, "R3 R5 collide plus store");
        cyc(0, 0, 1, 11, 0, 0, 0, "R3 released");
        // Store blocked by port 0, then by port 1.
        cyc(1, 3, 0, 0, 1, 19, 32'hB019_0019, "R4 blocked by ld0");
        cyc(0, 0, 0, 0, 1, 19, 32'hB019_0019, "R5 retry");
        cyc(1, 19, 1, 5, 0, 0, 0, "R9 read stored");
        cyc(1, 0, 1, 4, 1, 20, 32'hC020_0020, "R4 blocked by ld1");
        cyc(1, 0, 1, 1, 1, 20, 32'hC020_0020, "R5 loads elsewhere");
        cyc(0, 0, 1, 20, 0, 0, 0, "R9 port1 alone");
        // Same-word race.
        cyc(1, 6, 0, 0, 1, 6, 32'hDEAD_0006, "R7 race");
        cyc(0, 0, 1, 2, 1, 6, 32'hDEAD_0006, "R7 store after race");
        cyc(1, 6, 1, 14, 0, 0, 0, "R9 new word");
        cyc(0, 0, 0, 0, 0, 0, 0, "R6 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule